// File: doc/BRIEF.md
# Sine/Cosine Acquisition Sequencer

This block lets one analog-to-digital converter serve up to eight resolver channels. Each channel has a sine input and a cosine input. The block holds a scan position made of a channel number and a sine/cosine select bit, and it drives that position to the external input multiplexer. It pulses the converter's start line and waits for end-of-conversion. It then stores the returned 12-bit word in a small sample memory and steps the scan position.

Each channel is therefore converted twice in a row: sine first, then cosine. After the cosine of the last active channel, the scan wraps back to channel 0. When both words of a channel are stored, a one-cycle pulse that carries the channel number tells the angle computation downstream that it can start. Scanning can run freely or one conversion per request. A clear input returns the scan to channel 0. A load input jumps the scan to a chosen channel.

Top module: `sincos_acq_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, `adc_start_o` and `pair_ready_o` are low and the scan position is channel 0, sine (`mux_ch_o` = 0, `mux_cos_o` = 0).
- R2: A channel is always entered on its sine input. Whenever `mux_ch_o` takes a new value, `mux_cos_o` is 0 in that same cycle.
- R3: Each accepted end-of-conversion steps the 4-bit position {channel, select}. Sine (select 0) goes to the same channel's cosine (select 1). Cosine goes to the next channel's sine. The position changes at no other time except clear and load.
- R4: `clear_i` sets the position to channel 0, sine, on the next edge. It abandons any conversion in flight and wins over `load_i`.
- R5: After the cosine of a channel whose number is greater than or equal to `last_ch_i`, the next position is channel 0, sine.
- R6: `load_i` (without clear) sets the position to `load_ch_i`, sine, on the next edge. It abandons any conversion in flight, and scanning continues in sequence from that channel.
- R7: `adc_start_o` is a one-cycle pulse, and at most one conversion is outstanding. A request (`run_i` high or `step_i` high) that arrives while a conversion is outstanding is ignored. With `run_i` held high, the next start comes in the second cycle after the cycle in which end-of-conversion was sampled, which is after the sample has been written.
- R8: After a cosine sample is stored, `pair_ready_o` is high for exactly one cycle, the cycle after end-of-conversion was sampled. `pair_ch_o` then gives that sample's channel.
- R9: An `adc_eoc_i` pulse while no conversion is outstanding is ignored. It causes no write, no position step and no `pair_ready_o`.
- R10: The sample taken at channel c with select s is stored unchanged, polarity MSB included, at memory word 2*c + s. `rd_data_o` shows word `rd_addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | Free-running scan request, level |
| step_i | input | 1 | Single-conversion request |
| clear_i | input | 1 | Return scan to channel 0, sine |
| load_i | input | 1 | Jump scan to `load_ch_i`, sine |
| load_ch_i | input | 3 | Channel number for load |
| last_ch_i | input | 3 | Highest active channel |
| adc_start_o | output | 1 | Converter start pulse |
| adc_eoc_i | input | 1 | Converter end-of-conversion pulse |
| adc_data_i | input | 12 | Converter result, MSB is polarity |
| mux_ch_o | output | 3 | Channel address to the multiplexer |
| mux_cos_o | output | 1 | 0 selects sine, 1 selects cosine |
| rd_addr_i | input | 4 | Sample memory read word |
| rd_data_o | output | 12 | Sample memory read data |
| pair_ready_o | output | 1 | Both samples of a channel stored |
| pair_ch_o | output | 3 | Channel of the completed pair |

## Verification
The scan order is tried in several ways:
- A full eight-channel sweep separates the sine/cosine stepping from the channel stepping.
- Short scans with a small last channel show whether the wrap point is read correctly.
- A load beyond the last active channel, and a load made between a sine and its cosine, show whether the select bit is forced to sine and how the wrap behaves from above the limit.
- Single-step requests made during a conversion, and end-of-conversion pulses made with no conversion outstanding, show whether the block accepts events only in the right state.

A final read of every written memory word shows whether each sample landed at its own address.

// File: rtl/sincos_acq_pkg.sv
package sincos_acq_pkg;
  typedef enum logic {
    ACQ_IDLE = 1'b0,
    ACQ_BUSY = 1'b1
  } acq_state_e;
endpackage

// File: rtl/sincos_acq_rst_sync.sv
module sincos_acq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sincos_acq_addr.sv
// Scan position: channel number plus sine/cosine select.
module sincos_acq_addr #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            ld_i,
  input  logic [CH_W-1:0] ld_ch_i,
  input  logic [CH_W-1:0] last_ch_i,
  input  logic            adv_i,
  output logic [CH_W-1:0] ch_o,
  output logic            cos_o
);
  localparam logic [CH_W-1:0] CH_ONE = 1;

  logic [CH_W-1:0] ch_q, ch_d;
  logic            cos_q, cos_d;
  logic            pos_en;

  always_comb begin
    ch_d   = ch_q;
    cos_d  = cos_q;
    pos_en = clr_i | ld_i | adv_i;
    if (clr_i) begin
      ch_d  = '0;
      cos_d = 1'b0;
    end else if (ld_i) begin
      ch_d  = ld_ch_i;
      cos_d = 1'b0;
    end else if (adv_i) begin
      if (!cos_q) begin
        cos_d = 1'b1;
      end else begin
        cos_d = 1'b0;
        ch_d  = (ch_q >= last_ch_i) ? '0 : ch_q + CH_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q  <= '0;
      cos_q <= 1'b0;
    end else if (pos_en) begin
      ch_q  <= ch_d;
      cos_q <= cos_d;
    end
  end

  assign ch_o  = ch_q;
  assign cos_o = cos_q;
endmodule

// File: rtl/sincos_acq_ctrl.sv
// Conversion handshake: one outstanding conversion at a time.
module sincos_acq_ctrl
  import sincos_acq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic abort_i,
  input  logic eoc_i,
  output logic start_o,
  output logic wr_o
);
  acq_state_e st_q, st_d;
  logic       start_q, start_d;

  always_comb begin
    st_d    = st_q;
    start_d = 1'b0;
    wr_o    = 1'b0;
    case (st_q)
      ACQ_IDLE: begin
        if (req_i && !abort_i) begin
          st_d    = ACQ_BUSY;
          start_d = 1'b1;
        end
      end
      ACQ_BUSY: begin
        if (abort_i) begin
          st_d = ACQ_IDLE;
        end else if (eoc_i) begin
          wr_o = 1'b1;
          st_d = ACQ_IDLE;
        end
      end
      default: st_d = ACQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ACQ_IDLE;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
    end
  end

  assign start_o = start_q;
endmodule

// File: rtl/sincos_acq_mem.sv
// Sample store, one word per channel and select; combinational read.
module sincos_acq_mem #(
  parameter int AW = 4,
  parameter int W  = 12
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] word_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) word_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = word_q[raddr_i];
endmodule

// File: rtl/sincos_acq_seq.sv
module sincos_acq_seq #(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 12,
  parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic                step_i,
  input  logic                clear_i,
  input  logic                load_i,
  input  logic [CH_W-1:0]     load_ch_i,
  input  logic [CH_W-1:0]     last_ch_i,
  output logic                adc_start_o,
  input  logic                adc_eoc_i,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  output logic [CH_W-1:0]     mux_ch_o,
  output logic                mux_cos_o,
  input  logic [CH_W:0]       rd_addr_i,
  output logic [SAMPLE_W-1:0] rd_data_o,
  output logic                pair_ready_o,
  output logic [CH_W-1:0]     pair_ch_o
);
  localparam int ADDR_W = CH_W + 1;

  logic            rst_sync_n;
  logic            abort;
  logic            wr_en;
  logic [CH_W-1:0] ch;
  logic            cos_sel;
  logic            pair_d, pair_q;
  logic [CH_W-1:0] pair_ch_q;

  sincos_acq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign abort = clear_i | load_i;

  sincos_acq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req_i   (run_i | step_i),
    .abort_i (abort),
    .eoc_i   (adc_eoc_i),
    .start_o (adc_start_o),
    .wr_o    (wr_en)
  );

  sincos_acq_addr #(.CH_W(CH_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_i     (clear_i),
    .ld_i      (load_i),
    .ld_ch_i   (load_ch_i),
    .last_ch_i (last_ch_i),
    .adv_i     (wr_en),
    .ch_o      (ch),
    .cos_o     (cos_sel)
  );

  sincos_acq_mem #(.AW(ADDR_W), .W(SAMPLE_W)) u_mem (
    .clk     (clk),
    .we_i    (wr_en),
    .waddr_i ({ch, cos_sel}),
    .wdata_i (adc_data_i),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  always_comb pair_d = wr_en & cos_sel;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pair_q    <= 1'b0;
      pair_ch_q <= '0;
    end else begin
      pair_q <= pair_d;
      if (pair_d) pair_ch_q <= ch;
    end
  end

  assign mux_ch_o     = ch;
  assign mux_cos_o    = cos_sel;
  assign pair_ready_o = pair_q;
  assign pair_ch_o    = pair_ch_q;
endmodule

// File: rtl/sincos_acq_seq_chk.sv
module sincos_acq_seq_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clear_i,
  input logic            load_i,
  input logic [CH_W-1:0] load_ch_i,
  input logic            adc_start_o,
  input logic            adc_eoc_i,
  input logic [CH_W-1:0] mux_ch_o,
  input logic            mux_cos_o,
  input logic            pair_ready_o,
  input logic [CH_W-1:0] pair_ch_o
);
  AST_SINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !load_i) |=> (mux_ch_o == $past(mux_ch_o)) || !mux_cos_o); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_eoc_i && !clear_i && !load_i) |=> $stable({mux_ch_o, mux_cos_o})); // R3

  AST_CLEAR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (mux_ch_o == '0) && !mux_cos_o); // R4

  AST_LOAD_JAM: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clear_i) |=> (mux_ch_o == $past(load_ch_i)) && !mux_cos_o); // R6

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |=> !adc_start_o); // R7

  AST_PAIR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ready_o |-> $past(mux_cos_o) && ($past(mux_ch_o) == pair_ch_o)); // R8

  AST_PAIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ready_o |=> !pair_ready_o); // R8
endmodule

bind sincos_acq_seq sincos_acq_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .clear_i      (clear_i),
  .load_i       (load_i),
  .load_ch_i    (load_ch_i),
  .adc_start_o  (adc_start_o),
  .adc_eoc_i    (adc_eoc_i),
  .mux_ch_o     (mux_ch_o),
  .mux_cos_o    (mux_cos_o),
  .pair_ready_o (pair_ready_o),
  .pair_ch_o    (pair_ch_o)
);

// File: tb/sincos_acq_seq_bench.sv
module sincos_acq_seq_bench;
  localparam int CH_W = 3;
  localparam int W    = 12;
  localparam int LAT  = 3;

  logic          clk = 1'b0;
  logic          rst_n, run_i, step_i, clear_i, load_i;
  logic [CH_W-1:0] load_ch_i, last_ch_i;
  logic          adc_start_o, adc_eoc_i;
  logic [W-1:0]  adc_data_i;
  logic [CH_W-1:0] mux_ch_o;
  logic          mux_cos_o;
  logic [CH_W:0] rd_addr_i;
  logic [W-1:0]  rd_data_o;
  logic          pair_ready_o;
  logic [CH_W-1:0] pair_ch_o;

  always #10 clk = ~clk;

  sincos_acq_seq u_sincos_acq_seq (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .step_i(step_i),
    .clear_i(clear_i), .load_i(load_i), .load_ch_i(load_ch_i),
    .last_ch_i(last_ch_i), .adc_start_o(adc_start_o), .adc_eoc_i(adc_eoc_i),
    .adc_data_i(adc_data_i), .mux_ch_o(mux_ch_o), .mux_cos_o(mux_cos_o),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .pair_ready_o(pair_ready_o), .pair_ch_o(pair_ch_o)
  );

  int    checks = 0;
  int    errors = 0;
  int    pair_q[$];
  logic [W-1:0] shadow [16];
  bit    written [16];
  int    exp_ch = 0;
  bit    exp_cos = 0;
  int    last_m = 7;
  int    lat = 0;
  bit    model_on = 1;
  bit    eoc_drv = 0;
  bit    mon_on = 0;
  int    seq = 0;
  int    starts = 0;
  int    since_eoc = -1;
  string tag = "R3";
  bit    done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void advance();
    if (!exp_cos) exp_cos = 1;
    else begin
      exp_cos = 0;
      exp_ch = (exp_ch >= last_m) ? 0 : exp_ch + 1;
    end
  endfunction

  // ADC responder and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (eoc_drv) begin adc_eoc_i = 1'b0; eoc_drv = 0; end
        if (pair_ready_o) begin
          if (pair_q.size() == 0) chk(0, "R8", 1, 0);
          else begin
            int e;
            e = pair_q.pop_front();
            chk(int'(pair_ch_o) == e, "R8", int'(pair_ch_o), e);
          end
        end
        if (since_eoc >= 0) since_eoc++;
        if (adc_start_o) begin
          starts++;
          chk(int'({mux_ch_o, mux_cos_o}) == exp_ch * 2 + int'(exp_cos), tag,
              int'({mux_ch_o, mux_cos_o}), exp_ch * 2 + int'(exp_cos));
          if (since_eoc >= 0) chk(since_eoc == 2, "R7", since_eoc, 2);
          chk(lat == 0, "R7", lat, 0);
          since_eoc = -1;
          lat = LAT;
        end else if (lat > 0) begin
          lat--;
          if (lat == 0 && model_on) begin
            int a;
            seq++;
            a = exp_ch * 2 + int'(exp_cos);
            adc_data_i = W'((seq * 1237 + 300) % 4096);
            adc_eoc_i = 1'b1;
            eoc_drv = 1;
            shadow[a] = adc_data_i;
            written[a] = 1;
            if (exp_cos) pair_q.push_back(exp_ch);
            advance();
            since_eoc = 0;
          end
        end
      end
    end
  end

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic run_conv(input int n);
    int target;
    target = starts + n;
    since_eoc = -1;
    run_i = 1'b1;
    while (starts < target) @(negedge clk);
    run_i = 1'b0;
    settle();
  endtask

  task automatic do_load(input int ch);
    @(negedge clk);
    load_i = 1'b1; load_ch_i = CH_W'(ch);
    @(negedge clk);
    load_i = 1'b0;
    exp_ch = ch; exp_cos = 0;
    chk(int'(mux_ch_o) == ch && !mux_cos_o, "R6", int'({mux_ch_o, mux_cos_o}), ch * 2);
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    rst_n = 1'b0; run_i = 0; step_i = 0; clear_i = 0; load_i = 0;
    load_ch_i = '0; last_ch_i = 3'd7; adc_eoc_i = 0; adc_data_i = '0; rd_addr_i = '0;
    repeat (4) @(negedge clk);
    chk(!adc_start_o && !pair_ready_o, "R1", int'({adc_start_o, pair_ready_o}), 0);
    chk({mux_ch_o, mux_cos_o} == 4'd0, "R1", int'({mux_ch_o, mux_cos_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!adc_start_o && {mux_ch_o, mux_cos_o} == 4'd0, "R1",
        int'({adc_start_o, mux_ch_o, mux_cos_o}), 0);
    mon_on = 1;

    // R2 R3: full sweep over eight channels, then the wrap to channel 0
    tag = "R3"; run_conv(16);
    tag = "R5"; run_conv(2);

    // R5: shorter scan, last active channel 2
    @(negedge clk); last_ch_i = 3'd2; last_m = 2;
    tag = "R5"; run_conv(8);

    // R6: load between sine and cosine, then beyond last channel
    tag = "R6"; run_conv(1);
    do_load(4);
    tag = "R6"; run_conv(1);
    do_load(6);
    tag = "R5"; run_conv(3);

    // R4: clear from mid-pair, and clear winning over load
    tag = "R4"; run_conv(1);
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0; exp_ch = 0; exp_cos = 0;
    chk({mux_ch_o, mux_cos_o} == 4'd0, "R4", int'({mux_ch_o, mux_cos_o}), 0);
    run_conv(3);
    @(negedge clk); clear_i = 1'b1; load_i = 1'b1; load_ch_i = 3'd5;
    @(negedge clk); clear_i = 1'b0; load_i = 1'b0; exp_ch = 0; exp_cos = 0;
    chk({mux_ch_o, mux_cos_o} == 4'd0, "R4", int'({mux_ch_o, mux_cos_o}), 0);

    // R7: step request during a conversion is ignored
    begin
      int s0;
      s0 = starts; tag = "R7"; since_eoc = -1;
      step_i = 1'b1; @(negedge clk); step_i = 1'b0;
      @(negedge clk);
      step_i = 1'b1; @(negedge clk); step_i = 1'b0;
      repeat (12) @(negedge clk);
      chk(starts == s0 + 1, "R7", starts - s0, 1);
    end

    // R9: end-of-conversion with nothing outstanding
    begin
      int s0;
      logic [3:0] pos;
      s0 = starts; pos = {mux_ch_o, mux_cos_o};
      adc_data_i = 12'hABC; adc_eoc_i = 1'b1;
      @(negedge clk); adc_eoc_i = 1'b0;
      chk(!pair_ready_o, "R9", int'(pair_ready_o), 0);
      chk({mux_ch_o, mux_cos_o} == pos, "R9", int'({mux_ch_o, mux_cos_o}), int'(pos));
      repeat (4) @(negedge clk);
      chk(starts == s0 && {mux_ch_o, mux_cos_o} == pos, "R9", starts - s0, 0);
    end

    // R10: every written word reads back at 2*channel + select
    for (int a = 0; a < 16; a++) begin
      if (written[a]) begin
        rd_addr_i = 4'(a);
        #1;
        chk(rd_data_o == shadow[a], "R10", int'(rd_data_o), int'(shadow[a]));
      end
    end
    chk(pair_q.size() == 0, "R8", pair_q.size(), 0);
    finish_sim();
  end
endmodule